// File: doc/BRIEF.md
# Signalling Multiframe Aligner

This block finds and tracks the 16-frame channel-associated signalling multiframe in a 2.048 Mbit/s primary-rate receive stream. It works only once basic frame alignment is present. Once per frame it receives the time slot 16 octet, marked by a one-cycle strobe. While hunting, it locks onto the first octet whose upper nibble is the all-zero alignment pattern. From that point it counts frames modulo 16, with the alignment frame as frame 0.

While locked, the block checks the upper nibble only in frame 0 of each multiframe. One errored multiframe is tolerated. A good multiframe clears the error history. A second consecutive errored multiframe drops alignment and starts a new hunt. The block also hunts again when basic alignment is lost or when a manual reframe is requested.

A freeze output tells the downstream signalling decoder to hold its last signalling values while the multiframe is not aligned. The alignment status is active low.

Top module: `cas_mf_aligner`

## Requirements
- R1: After synchronous reset the block is hunting: `mfsync_n`=1, `sig_freeze`=1, `frame_idx`=0.
- R2: While `basic_lock`=0 the block stays hunting, and an all-zero upper nibble on a strobe does not align it.
- R3: While hunting with `basic_lock`=1, the first strobe whose `ts16_octet[7:4]`=4'b0000 aligns the block. On the next clock edge `mfsync_n`=0, `sig_freeze`=0 and `frame_idx`=0.
- R4: While hunting, a strobe whose upper nibble is not 0000 leaves the block hunting. The lower nibble `ts16_octet[3:0]` never takes part in the pattern test.
- R5: While aligned, each strobe advances `frame_idx` by one, and 15 wraps to 0. A cycle without a strobe leaves `frame_idx` unchanged.
- R6: While aligned, the upper nibble is tested only on the strobe that takes `frame_idx` from 15 to 0. A non-zero nibble in any other frame has no effect on alignment.
- R7: A single errored multiframe (non-zero nibble at frame 0) keeps alignment. A good multiframe resets the consecutive-error count to zero.
- R8: On the second consecutive errored multiframe, the next clock edge gives `mfsync_n`=1, `sig_freeze`=1 and `frame_idx`=0.
- R9: `manual_reframe`=1 returns the block to hunting on the next edge. It takes priority over a strobe in the same cycle.
- R10: When `basic_lock` falls, the block returns to hunting on the next edge and clears its frame and error counts.
- R11: `sig_freeze` is 1 exactly when the block is not aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| basic_lock | input | 1 | Basic frame alignment present |
| manual_reframe | input | 1 | Restart the multiframe hunt |
| ts16_valid | input | 1 | One-cycle strobe per frame marking `ts16_octet` |
| ts16_octet | input | 8 | Received time slot 16 octet; bits 7:4 carry the alignment nibble in frame 0 |
| mfsync_n | output | 1 | Multiframe alignment status, low when aligned |
| frame_idx | output | 4 | Frame position within the multiframe, 0 to 15 |
| sig_freeze | output | 1 | Hold signalling values while not aligned |

## Verification
The bench drives octets of three kinds while hunting: an upper nibble of zero with a non-zero lower nibble, a non-zero upper nibble with a zero lower nibble, and fully non-zero octets. These show that only the upper nibble decides alignment. Once the block is aligned, non-zero octets placed off frame 0 separate a position-gated check from a check on every frame.

Complete multiframes are then sent in the sequences bad-good-bad and bad-bad. These separate a consecutive-error count from a cumulative one, and show that loss happens on exactly the second error. Reframe requests that coincide with a zero-nibble strobe, and a drop of basic lock, confirm that the restart paths take priority.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;

    localparam logic [3:0] MFAS_PATTERN = 4'b0000;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } mf_state_t;

    typedef struct packed {
        logic [3:0] mf_nib;
        logic [3:0] spare_nib;
    } ts16_t;

    function automatic logic is_mfas(input ts16_t oct);
        return oct.mf_nib == MFAS_PATTERN;
    endfunction

endpackage

// File: rtl/cas_mf_pattern.sv
module cas_mf_pattern
    import cas_mf_pkg::*;
(
    input  logic [7:0] octet_i,
    output logic       hit_o
);
    ts16_t oct;

    always_comb begin
        oct   = ts16_t'(octet_i);
        hit_o = is_mfas(oct);
    end
endmodule

// File: rtl/cas_mf_frame_ctr.sv
module cas_mf_frame_ctr #(
    parameter int MF_LEN = 16,
    localparam int FR_W = $clog2(MF_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            adv_i,
    output logic [FR_W-1:0] cnt_o,
    output logic            last_o
);
    localparam logic [FR_W-1:0] LAST = FR_W'(MF_LEN - 1);

    assign last_o = (cnt_o == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (adv_i)
            cnt_o <= last_o ? '0 : cnt_o + 1'b1;
    end

    // R5
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clr_i && cnt_o != LAST) |=> cnt_o == FR_W'($past(cnt_o) + 1'b1));

    // R5
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clr_i && cnt_o == LAST) |=> cnt_o == '0);

    // R5
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/cas_mf_loss_ctr.sv
module cas_mf_loss_ctr #(
    parameter int LOSS_LIMIT = 2,
    localparam int LC_W = $clog2(LOSS_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic good_i,
    input  logic bad_i,
    output logic lost_o
);
    logic [LC_W-1:0] err_cnt;

    assign lost_o = bad_i && (err_cnt == LC_W'(LOSS_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i || good_i || lost_o)
            err_cnt <= '0;
        else if (bad_i)
            err_cnt <= err_cnt + 1'b1;
    end

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        good_i |=> err_cnt == '0);

    // R8
    err_bound_chk: assert property (@(posedge clk) disable iff (rst)
        err_cnt < LC_W'(LOSS_LIMIT));
endmodule

// File: rtl/cas_mf_aligner.sv
module cas_mf_aligner
    import cas_mf_pkg::*;
#(
    parameter int MF_LEN     = 16,
    parameter int LOSS_LIMIT = 2,
    localparam int FR_W      = $clog2(MF_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            basic_lock,
    input  logic            manual_reframe,
    input  logic            ts16_valid,
    input  logic [7:0]      ts16_octet,
    output logic            mfsync_n,
    output logic [FR_W-1:0] frame_idx,
    output logic            sig_freeze
);
    mf_state_t state, state_nx;
    logic nib_ok, restart, hunt_hit, mf_start, good_mf, bad_mf, lost;
    logic fr_last;

    cas_mf_pattern u_pattern (
        .octet_i (ts16_octet),
        .hit_o   (nib_ok)
    );

    assign restart  = !basic_lock || manual_reframe;
    assign hunt_hit = (state == ST_HUNT) && ts16_valid && nib_ok && !restart;
    assign mf_start = (state == ST_LOCK) && ts16_valid && fr_last && !restart;
    assign good_mf  = mf_start && nib_ok;
    assign bad_mf   = mf_start && !nib_ok;

    cas_mf_frame_ctr #(.MF_LEN(MF_LEN)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (restart || hunt_hit || lost || state == ST_HUNT),
        .adv_i  ((state == ST_LOCK) && ts16_valid),
        .cnt_o  (frame_idx),
        .last_o (fr_last)
    );

    cas_mf_loss_ctr #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (restart || state == ST_HUNT),
        .good_i (good_mf),
        .bad_i  (bad_mf),
        .lost_o (lost)
    );

    always_comb begin
        state_nx = state;
        if (restart)
            state_nx = ST_HUNT;
        else if (hunt_hit)
            state_nx = ST_LOCK;
        else if (lost)
            state_nx = ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_HUNT;
        else
            state <= state_nx;
    end

    assign mfsync_n   = (state != ST_LOCK);
    assign sig_freeze = (state != ST_LOCK);

    // R2
    no_lock_without_basic_chk: assert property (@(posedge clk) disable iff (rst)
        !basic_lock |=> mfsync_n);

    // R9
    reframe_restart_chk: assert property (@(posedge clk) disable iff (rst)
        manual_reframe |=> (mfsync_n && frame_idx == '0));

    // R3
    first_pattern_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mfsync_n && basic_lock && !manual_reframe && ts16_valid
         && ts16_octet[7:4] == 4'b0000) |=> (!mfsync_n && frame_idx == '0));

    // R4
    hunt_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (mfsync_n && !(ts16_valid && ts16_octet[7:4] == 4'b0000)) |=> mfsync_n);

    // R6
    off_frame_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!mfsync_n && basic_lock && !manual_reframe && frame_idx != FR_W'(MF_LEN - 1))
        |=> !mfsync_n);
endmodule

// File: tb/test_cas_mf_aligner.sv
module test_cas_mf_aligner;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, basic_lock, manual_reframe, ts16_valid;
    logic [7:0] ts16_octet;
    logic mfsync_n, sig_freeze;
    logic [3:0] frame_idx;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_mf_aligner i_cas_mf_aligner (
        .clk(clk), .rst(rst), .basic_lock(basic_lock),
        .manual_reframe(manual_reframe), .ts16_valid(ts16_valid),
        .ts16_octet(ts16_octet), .mfsync_n(mfsync_n),
        .frame_idx(frame_idx), .sig_freeze(sig_freeze)
    );

    typedef struct packed {
        logic       lock;
        logic       rf;
        logic       vld;
        logic [7:0] oct;
        logic       exp_n;
        logic [3:0] exp_idx;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 4'd0},  // R2 no basic lock
        '{1'b1, 1'b0, 1'b1, 8'hF0, 1'b1, 4'd0},  // R4 upper nibble non-zero
        '{1'b1, 1'b0, 1'b1, 8'h8B, 1'b1, 4'd0},  // R4
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd0},  // R4 no strobe
        '{1'b1, 1'b0, 1'b1, 8'h0F, 1'b0, 4'd0},  // R3 aligns, lower nibble ignored
        '{1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 4'd1},  // R6 off-frame error ignored
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd1},  // R5 hold without strobe
        '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 4'd2},  // R5 advance
        '{1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 4'd0},  // R9 reframe beats strobe
        '{1'b1, 1'b0, 1'b1, 8'h35, 1'b1, 4'd0},  // R4
        '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 4'd0},  // R3 realign
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd0},  // R10 basic lock lost
        '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 4'd0}   // R3
    };

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_state(input string req, input logic exp_n, input int exp_idx);
        check({req, " mfsync_n"}, mfsync_n, exp_n);
        check({req, " frame_idx"}, frame_idx, exp_idx);
        check({req, " sig_freeze R11"}, sig_freeze, exp_n);
    endtask

    task automatic apply(input logic lk, input logic rf, input logic vl, input logic [7:0] oc);
        @(negedge clk);
        basic_lock = lk; manual_reframe = rf; ts16_valid = vl; ts16_octet = oc;
        @(negedge clk);
        manual_reframe = 1'b0; ts16_valid = 1'b0; ts16_octet = 8'hAA;
    endtask

    task automatic strobe(input logic [7:0] oc);
        apply(1'b1, 1'b0, 1'b1, oc);
    endtask

    task automatic fill15();
        for (int k = 0; k < 15; k++) strobe(8'hC3);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; basic_lock = 1'b0; manual_reframe = 1'b0;
        ts16_valid = 1'b0; ts16_octet = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset", 1'b1, 0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].lock, VECS[i].rf, VECS[i].vld, VECS[i].oct);
            check_state($sformatf("vector %0d", i), VECS[i].exp_n, VECS[i].exp_idx);
        end

        // aligned at frame 0 here
        fill15();
        check_state("R5 reach 15", 1'b0, 15);
        strobe(8'h50);                          // R7 first error
        check_state("R7 single error kept", 1'b0, 0);
        fill15();
        strobe(8'h00);                          // good clears count
        check_state("R7 good multiframe", 1'b0, 0);
        fill15();
        strobe(8'h70);                          // error again, count was cleared
        check_state("R7 count cleared", 1'b0, 0);
        fill15();
        strobe(8'hA0);                          // second consecutive error
        check_state("R8 loss", 1'b1, 0);
        strobe(8'h11);
        check_state("R4 hunting after loss", 1'b1, 0);
        strobe(8'h04);
        check_state("R3 realign after loss", 1'b0, 0);
        strobe(8'h00);
        check_state("R5 advance after realign", 1'b0, 1);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state("R1 mid-run reset", 1'b1, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule